// File: doc/BRIEF.md
# NAND Controller Configuration and Interrupt Register Block

This block is the register front end of a NAND flash controller. A host reaches it over a simple register bus made of a word address, 32-bit write data, byte enables, a write strobe, a read strobe and registered read data. It holds two configuration registers, for interface options and for bus timing. These two are guarded by a key: a host must write a fixed 16-bit key before each change, and the guard closes again after one accepted change. Other registers hold the interrupt mask, the chip-enable mode and a command port that issues a controller soft reset.

The controller core feeds the block a set of event inputs: NAND ready, controller ready, ECC ready, correctable decode error, decode failure, write-protect fault, and a 2-bit corrected-symbol count. A live status register shows these inputs as they are at the moment of the read. The rising edge of each event sets a sticky interrupt status bit. Reading the sticky register returns its contents and empties it in the same access. The interrupt output is a level, high while any unmasked sticky bit is set.

Top module: `nand_cfg_regs`

## Requirements
- R1: After reset the interface, timing, mask, sticky status and chip-enable registers read zero, the guard is closed, and irq, ctl_soft_rst, ce_auto and all cfg_* outputs are low.
- R2: A write to the interface register (word 2) or the timing register (word 3) while the guard is closed is ignored. The register's read value and its outputs stay unchanged.
- R3: A write of 0xA25E to the key register (word 1), with both low byte enables set, opens the guard. The next write to word 2 or word 3 is accepted and closes the guard, so a second write without a new key is ignored.
- R4: Interface register bits drive the outputs as follows: bit 3 drives cfg_wp_en, bit 2 drives cfg_large_blk, bit 1 drives cfg_long_addr and bit 0 drives cfg_bus16. The register reads back as written.
- R5: The timing register keeps bits 25:0, which drive tim_cfg: write-low at 3:0, write-high at 7:4, read-low at 11:8, read-high at 15:12, turnaround at 18:16, busy delay at 23:19 and chip-enable-to-access delay at 25:24. Bits 31:26 read zero.
- R6: The live status register (word 6) reads, at the cycle of the read, bit 0 NAND ready, bit 1 controller ready, bit 2 ECC ready, bit 3 decode error (errors detected), bits 5:4 ecc_fix_cnt and bit 6 decode failure.
- R7: The rising edge of an event input sets its sticky status bit in word 5. The layout is bit 5 NAND ready, bit 4 controller ready, bit 3 decode failure, bit 2 decode error, bit 1 ECC ready and bit 0 write-protect fault. An input held high does not set its bit again.
- R8: A read of word 5 returns the sticky bits and clears all of them in the same access.
- R9: When a rising event and a clearing read of word 5 fall in the same cycle, that event's bit is set after the read. The read itself returns the contents from before the event.
- R10: irq is high exactly when some sticky bit is set whose mask bit (word 4, same layout) is also set.
- R11: A write of 0xFF to the command register (word 0) gives a single-cycle pulse on ctl_soft_rst. Any other value gives no pulse.
- R12: Bit 0 of the chip-enable register (word 7) drives ce_auto, where 1 selects normal mode and the controller drives chip enable.
- R13: A key-register write of any value other than 0xA25E closes the guard, even if the guard was open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (4) | Word address |
| bus_wdata | input | BUS_W (32) | Write data |
| bus_be | input | BUS_W/8 (4) | Byte enables |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | BUS_W (32) | Read data, one cycle after the strobe |
| ev_nand_rdy | input | 1 | NAND device ready |
| ev_ctrl_rdy | input | 1 | Controller ready |
| ev_ecc_rdy | input | 1 | ECC ready |
| ev_dec_err | input | 1 | Correctable decode error |
| ev_dec_fail | input | 1 | Decode failure |
| ev_wp_fault | input | 1 | Write-protect fault |
| ecc_fix_cnt | input | 2 | Corrected symbols minus one |
| cfg_wp_en | output | 1 | Write-protect enable |
| cfg_large_blk | output | 1 | Large-block device |
| cfg_long_addr | output | 1 | Five-byte addressing |
| cfg_bus16 | output | 1 | 16-bit bus mode |
| tim_cfg | output | 26 | Timing fields |
| ce_auto | output | 1 | Controller drives chip enable |
| ctl_soft_rst | output | 1 | Soft reset pulse |
| irq | output | 1 | Level interrupt, active high |

## Verification
The bench builds the block with the default parameters: ADDR_W of 4, BUS_W of 32, the key 0xA25E, the reset command 0xFF and registered read data. With these values every word of the map is reachable, and the zeroed upper timing bits can be seen on the 32-bit read bus. The one-cycle read latency makes the collision case testable. The bench raises an event on the same edge as a clearing read, checks the stale value that read returns, and then checks that the bit survives. The guard is driven through open, accept, re-close, wrong-key and partial-byte-enable sequences.

// File: rtl/nand_cfg_pkg.sv
package nand_cfg_pkg;
   localparam int unsigned OFS_CMD  = 0;
   localparam int unsigned OFS_KEY  = 1;
   localparam int unsigned OFS_IFC  = 2;
   localparam int unsigned OFS_TIM  = 3;
   localparam int unsigned OFS_MASK = 4;
   localparam int unsigned OFS_STAT = 5;
   localparam int unsigned OFS_LIVE = 6;
   localparam int unsigned OFS_CEC  = 7;

   localparam int unsigned IFC_W  = 4;
   localparam int unsigned TIM_W  = 26;
   localparam int unsigned EV_N   = 6;
   localparam int unsigned LIVE_W = 7;

   typedef struct packed {
      logic wp_en;
      logic large_blk;
      logic long_addr;
      logic bus16;
   } ifc_t;
endpackage

// File: rtl/nand_cfg_preg.sv
module nand_cfg_preg #(
   parameter int unsigned W     = 4,
   parameter int unsigned BUS_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [BUS_W-1:0] wdata,
   input  logic [BUS_W-1:0] bmask,
   output logic [W-1:0]     q
);
   generate
      if (W > BUS_W) begin : g_bad_w
         $error("nand_cfg_preg: W exceeds BUS_W");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= (q & ~bmask[W-1:0]) | (wdata[W-1:0] & bmask[W-1:0]);
   end
endmodule

// File: rtl/nand_cfg_lock.sv
module nand_cfg_lock (
   input  logic clk,
   input  logic rst_n,
   input  logic key_wr,
   input  logic key_hit,
   input  logic prot_wr,
   output logic unlocked,
   output logic prot_we
);
   assign prot_we = prot_wr & unlocked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       unlocked <= 1'b0;
      else if (key_wr)  unlocked <= key_hit;
      else if (prot_we) unlocked <= 1'b0;
   end

   // R3
   relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prot_we |=> !unlocked);

   // R13
   badkey_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (key_wr && !key_hit) |=> !unlocked);
endmodule

// File: rtl/nand_cfg_irq.sv
module nand_cfg_irq #(
   parameter int unsigned EV_N = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [EV_N-1:0] ev,
   input  logic [EV_N-1:0] mask,
   input  logic            rd_clr,
   output logic [EV_N-1:0] sticky,
   output logic            irq
);
   logic [EV_N-1:0] ev_q;
   logic [EV_N-1:0] rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ev_q <= '0;
      else        ev_q <= ev;
   end

   assign rise = ev & ~ev_q;

   generate
      for (genvar i = 0; i < EV_N; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       sticky[i] <= 1'b0;
            else if (rise[i]) sticky[i] <= 1'b1;
            else if (rd_clr)  sticky[i] <= 1'b0;
         end
      end
   endgenerate

   assign irq = |(sticky & mask);

   // R7
   edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rise != '0) |=> ((sticky & $past(rise)) == $past(rise)));

   // R8 R9
   rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_clr |=> (sticky == $past(rise)));

   // R10
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sticky == '0) |-> !irq);
endmodule

// File: rtl/nand_cfg_regs.sv
module nand_cfg_regs
   import nand_cfg_pkg::*;
#(
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned BUS_W    = 32,
   parameter logic [15:0] LOCK_KEY = 16'hA25E,
   parameter logic [7:0]  RST_CMD  = 8'hFF,
   parameter bit          RD_REG   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [BUS_W-1:0]   bus_wdata,
   input  logic [BUS_W/8-1:0] bus_be,
   input  logic               bus_wr,
   input  logic               bus_rd,
   output logic [BUS_W-1:0]   bus_rdata,
   input  logic               ev_nand_rdy,
   input  logic               ev_ctrl_rdy,
   input  logic               ev_ecc_rdy,
   input  logic               ev_dec_err,
   input  logic               ev_dec_fail,
   input  logic               ev_wp_fault,
   input  logic [1:0]         ecc_fix_cnt,
   output logic               cfg_wp_en,
   output logic               cfg_large_blk,
   output logic               cfg_long_addr,
   output logic               cfg_bus16,
   output logic [25:0]        tim_cfg,
   output logic               ce_auto,
   output logic               ctl_soft_rst,
   output logic               irq
);
   localparam int unsigned BE_W = BUS_W / 8;

   generate
      if (BUS_W < TIM_W || (BUS_W % 8) != 0) begin : g_bad_bus
         $error("nand_cfg_regs: BUS_W must be a byte multiple holding the timing word");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("nand_cfg_regs: ADDR_W too small for the register map");
      end
   endgenerate

   logic [BUS_W-1:0] bmask;
   generate
      for (genvar b = 0; b < BE_W; b++) begin : g_bmask
         assign bmask[b*8 +: 8] = {8{bus_be[b]}};
      end
   endgenerate

   logic hit_cmd, hit_key, hit_ifc, hit_tim, hit_mask, hit_stat, hit_cec;
   assign hit_cmd  = (bus_addr == ADDR_W'(OFS_CMD));
   assign hit_key  = (bus_addr == ADDR_W'(OFS_KEY));
   assign hit_ifc  = (bus_addr == ADDR_W'(OFS_IFC));
   assign hit_tim  = (bus_addr == ADDR_W'(OFS_TIM));
   assign hit_mask = (bus_addr == ADDR_W'(OFS_MASK));
   assign hit_stat = (bus_addr == ADDR_W'(OFS_STAT));
   assign hit_cec  = (bus_addr == ADDR_W'(OFS_CEC));

   // key guard
   logic unlocked, prot_we;
   logic key_wr, key_hit, prot_wr;
   assign key_wr  = bus_wr & hit_key;
   assign key_hit = (bus_be[1:0] == 2'b11) && (bus_wdata[15:0] == LOCK_KEY);
   assign prot_wr = bus_wr & (hit_ifc | hit_tim);

   nand_cfg_lock u_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_wr   (key_wr),
      .key_hit  (key_hit),
      .prot_wr  (prot_wr),
      .unlocked (unlocked),
      .prot_we  (prot_we)
   );

   // protected registers
   logic [IFC_W-1:0] ifc_q;
   logic [TIM_W-1:0] tim_q;
   ifc_t             ifc_s;

   nand_cfg_preg #(.W(IFC_W), .BUS_W(BUS_W)) u_ifc (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (prot_we & hit_ifc),
      .wdata (bus_wdata),
      .bmask (bmask),
      .q     (ifc_q)
   );

   nand_cfg_preg #(.W(TIM_W), .BUS_W(BUS_W)) u_tim (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (prot_we & hit_tim),
      .wdata (bus_wdata),
      .bmask (bmask),
      .q     (tim_q)
   );

   assign ifc_s         = ifc_t'(ifc_q);
   assign cfg_wp_en     = ifc_s.wp_en;
   assign cfg_large_blk = ifc_s.large_blk;
   assign cfg_long_addr = ifc_s.long_addr;
   assign cfg_bus16     = ifc_s.bus16;
   assign tim_cfg       = tim_q;

   // open registers
   logic [EV_N-1:0] mask_q;
   logic            cec_q;
   logic            rst_pulse;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q    <= '0;
         cec_q     <= 1'b0;
         rst_pulse <= 1'b0;
      end else begin
         if (bus_wr && hit_mask)
            mask_q <= (mask_q & ~bmask[EV_N-1:0]) | (bus_wdata[EV_N-1:0] & bmask[EV_N-1:0]);
         if (bus_wr && hit_cec && bus_be[0])
            cec_q <= bus_wdata[0];
         rst_pulse <= bus_wr && hit_cmd && bus_be[0] && (bus_wdata[7:0] == RST_CMD);
      end
   end

   assign ce_auto      = cec_q;
   assign ctl_soft_rst = rst_pulse;

   // sticky interrupt status
   logic [EV_N-1:0] ev_vec;
   logic [EV_N-1:0] sticky;
   logic            rd_clr;
   assign ev_vec = {ev_nand_rdy, ev_ctrl_rdy, ev_dec_fail, ev_dec_err, ev_ecc_rdy, ev_wp_fault};
   assign rd_clr = bus_rd & hit_stat;

   nand_cfg_irq #(.EV_N(EV_N)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .ev     (ev_vec),
      .mask   (mask_q),
      .rd_clr (rd_clr),
      .sticky (sticky),
      .irq    (irq)
   );

   // read path
   logic [LIVE_W-1:0] live;
   logic [BUS_W-1:0]  rd_val;
   assign live = {ev_dec_fail, ecc_fix_cnt, ev_dec_err, ev_ecc_rdy, ev_ctrl_rdy, ev_nand_rdy};

   always_comb begin
      rd_val = '0;
      if (hit_ifc)  rd_val[IFC_W-1:0]  = ifc_q;
      if (hit_tim)  rd_val[TIM_W-1:0]  = tim_q;
      if (hit_mask) rd_val[EV_N-1:0]   = mask_q;
      if (hit_stat) rd_val[EV_N-1:0]   = sticky;
      if (hit_live_f(bus_addr)) rd_val[LIVE_W-1:0] = live;
      if (hit_cec)  rd_val[0]          = cec_q;
   end

   function automatic logic hit_live_f(input logic [ADDR_W-1:0] a);
      return a == ADDR_W'(OFS_LIVE);
   endfunction

   generate
      if (RD_REG) begin : g_rd_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      bus_rdata <= '0;
            else if (bus_rd) bus_rdata <= rd_val;
            else             bus_rdata <= '0;
         end
      end else begin : g_rd_comb
         assign bus_rdata = bus_rd ? rd_val : '0;
      end
   endgenerate

   // R2
   locked_ifc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit_ifc && !unlocked) |=> $stable(ifc_q));

   // R2
   locked_tim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit_tim && !unlocked) |=> $stable(tim_q));

   // R11
   soft_rst_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_soft_rst |-> $past(bus_wr && hit_cmd && bus_wdata[7:0] == RST_CMD));
endmodule

// File: tb/sim_nand_cfg_regs.sv
module sim_nand_cfg_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [3:0]  bus_be = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;
   logic ev_nand_rdy = 0, ev_ctrl_rdy = 0, ev_ecc_rdy = 0;
   logic ev_dec_err = 0, ev_dec_fail = 0, ev_wp_fault = 0;
   logic [1:0]  ecc_fix_cnt = '0;
   logic cfg_wp_en, cfg_large_blk, cfg_long_addr, cfg_bus16;
   logic [25:0] tim_cfg;
   logic ce_auto, ctl_soft_rst, irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   nand_cfg_regs u0 (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_be = '0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic pulse_ev(input int idx);
      @(negedge clk);
      case (idx)
         5: ev_nand_rdy = 1; 4: ev_ctrl_rdy = 1; 3: ev_dec_fail = 1;
         2: ev_dec_err = 1;  1: ev_ecc_rdy = 1;  default: ev_wp_fault = 1;
      endcase
      @(negedge clk);
      {ev_nand_rdy, ev_ctrl_rdy, ev_dec_fail, ev_dec_err, ev_ecc_rdy, ev_wp_fault} = '0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(4'd2, d); chk("R1 ifc", d, 0);
      rd(4'd3, d); chk("R1 tim", d, 0);
      rd(4'd4, d); chk("R1 mask", d, 0);
      rd(4'd5, d); chk("R1 stat", d, 0);
      rd(4'd7, d); chk("R1 cec", d, 0);
      chk("R1 outs", {irq, ctl_soft_rst, ce_auto, cfg_wp_en, cfg_large_blk, cfg_long_addr, cfg_bus16, 6'd0, tim_cfg}, 0);
   endtask

   task automatic t_locked();
      logic [31:0] d;
      wr(4'd2, 32'hF);
      rd(4'd2, d); chk("R2 ifc locked", d, 0);
      chk("R2 wp out", {31'd0, cfg_wp_en}, 0);
      wr(4'd3, 32'h00ABCDEF);
      rd(4'd3, d); chk("R2 tim locked", d, 0);
   endtask

   task automatic t_unlock();
      logic [31:0] d;
      wr(4'd1, 32'hA25E);
      wr(4'd2, 32'h6);
      rd(4'd2, d); chk("R3 ifc accepted", d, 32'h6);
      chk("R4 outputs", {28'd0, cfg_wp_en, cfg_large_blk, cfg_long_addr, cfg_bus16}, 32'h6);
      wr(4'd2, 32'hF);
      rd(4'd2, d); chk("R3 relocked", d, 32'h6);
      wr(4'd1, 32'hA25E);
      wr(4'd2, 32'h9);
      chk("R4 wp bus16", {28'd0, cfg_wp_en, cfg_large_blk, cfg_long_addr, cfg_bus16}, 32'h9);
      wr(4'd1, 32'hA25E);
      wr(4'd3, 32'hFFFFFFFF);
      rd(4'd3, d); chk("R5 tim width", d, 32'h03FFFFFF);
      wr(4'd1, 32'hA25E);
      wr(4'd3, 32'h01234567);
      chk("R5 tim_cfg", {6'd0, tim_cfg}, 32'h01234567);
   endtask

   task automatic t_badkey();
      logic [31:0] d;
      wr(4'd1, 32'hA25F);
      wr(4'd2, 32'h3);
      rd(4'd2, d); chk("R13 wrong key", d, 32'h9);
      wr(4'd1, 32'hA25E);
      wr(4'd1, 32'h1234);
      wr(4'd2, 32'h3);
      rd(4'd2, d); chk("R13 relock by bad key", d, 32'h9);
      wr(4'd1, 32'hA25E, 4'b0001);
      wr(4'd2, 32'h3);
      rd(4'd2, d); chk("R3 partial be key", d, 32'h9);
   endtask

   task automatic t_live();
      logic [31:0] d;
      @(negedge clk);
      ev_nand_rdy = 1; ev_dec_fail = 1; ev_dec_err = 1; ecc_fix_cnt = 2'b10;
      rd(4'd6, d); chk("R6 live a", d, 32'h69);
      @(negedge clk);
      {ev_nand_rdy, ev_dec_fail, ev_dec_err} = '0;
      ev_ctrl_rdy = 1; ev_ecc_rdy = 1; ecc_fix_cnt = 2'b01;
      rd(4'd6, d); chk("R6 live b", d, 32'h16);
      @(negedge clk);
      {ev_ctrl_rdy, ev_ecc_rdy} = '0; ecc_fix_cnt = '0;
      rd(4'd5, d);
   endtask

   task automatic t_sticky();
      logic [31:0] d;
      pulse_ev(4);
      rd(4'd5, d); chk("R7 ctrl bit", d, 32'h10);
      rd(4'd5, d); chk("R8 cleared", d, 0);
      @(negedge clk); ev_wp_fault = 1;
      @(negedge clk);
      rd(4'd5, d); chk("R7 wp bit", d, 32'h01);
      rd(4'd5, d); chk("R7 held level no reset", d, 0);
      @(negedge clk); ev_wp_fault = 0;
   endtask

   task automatic t_irq();
      logic [31:0] d;
      wr(4'd4, 32'h02);
      pulse_ev(5);
      chk("R10 masked low", {31'd0, irq}, 0);
      pulse_ev(1);
      chk("R10 unmasked high", {31'd0, irq}, 1);
      rd(4'd5, d); chk("R8 both bits", d, 32'h22);
      chk("R10 low after clear", {31'd0, irq}, 0);
      wr(4'd4, 32'h3F);
      rd(4'd4, d); chk("R10 mask readback", d, 32'h3F);
   endtask

   task automatic t_collide();
      logic [31:0] d;
      @(negedge clk);
      bus_addr = 4'd5; bus_rd = 1'b1; ev_dec_fail = 1;
      @(negedge clk);
      bus_rd = 1'b0;
      chk("R9 stale read", bus_rdata, 0);
      chk("R9 irq kept", {31'd0, irq}, 1);
      rd(4'd5, d); chk("R9 bit kept", d, 32'h08);
      @(negedge clk); ev_dec_fail = 0;
   endtask

   task automatic t_cmd();
      wr(4'd0, 32'h12);
      chk("R11 no pulse", {31'd0, ctl_soft_rst}, 0);
      wr(4'd0, 32'hFF);
      chk("R11 pulse", {31'd0, ctl_soft_rst}, 1);
      @(negedge clk);
      chk("R11 one cycle", {31'd0, ctl_soft_rst}, 0);
   endtask

   task automatic t_ce();
      logic [31:0] d;
      wr(4'd7, 32'h1);
      chk("R12 ce_auto on", {31'd0, ce_auto}, 1);
      rd(4'd7, d); chk("R12 readback", d, 1);
      wr(4'd7, 32'h0);
      chk("R12 ce_auto off", {31'd0, ce_auto}, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_locked();
      t_unlock();
      t_badkey();
      t_live();
      t_sticky();
      t_irq();
      t_collide();
      t_cmd();
      t_ce();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #500us;
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule